// File: doc/BRIEF.md
# Serial Port FIFO Pair with Receive Threshold Interrupt

This block holds the two byte queues of a serial port: one for received characters waiting for software and one for characters waiting to be shifted out. Each queue offers a push side, a pop side with the oldest byte always visible, an occupancy count and full/empty flags. A single 8-bit control byte, written through a one-cycle strobe, switches both queues on or off, empties either queue on demand and picks the receive threshold. Once receive occupancy reaches that threshold, an interrupt request is raised.

The control byte cannot be read back. Flush commands act once, in the cycle of the write, and leave nothing stored. Any change of the enable bit empties both queues, so toggling the queues on or off always starts them clean. The receive side keeps a sticky overrun flag for bytes that had to be dropped because the queue was full.

Top module: `sio_fifo_pair`

## Requirements
- R1: After reset both queues are disabled and empty, counts are 0, the threshold code is 00, and overrun and the interrupt request are low.
- R2: Bit 0 of a control write is the enable. A write with bit 0 = 1 enables the queues and applies bits 7:1 in that same write. A write with bit 0 = 0 disables them and its bits 7:1 are discarded.
- R3: A control write whose bit 0 differs from the current enable empties both queues and clears overrun at that clock edge, in either direction.
- R4: Bit 1 = 1 in a write with bit 0 = 1 empties the receive queue and clears overrun at that edge. It is a one-time action and nothing stays set.
- R5: Bit 2 = 1 in a write with bit 0 = 1 empties the transmit queue at that edge, leaving the receive queue untouched. It is also a one-time action.
- R6: Bits 5:3 of a control write have no effect.
- R7: Bits 7:6 select the receive threshold: 00 is 1 byte, 01 is 4, 10 is 8 and 11 is 14.
- R8: The interrupt request is high exactly when the queues are enabled and receive occupancy is at or above the threshold. It follows the count with no register delay, so it falls in the cycle a pop takes occupancy below the threshold.
- R9: Each queue holds 16 bytes in first-in first-out order. The read data shows the oldest byte, and count, full (count = 16) and empty (count = 0) follow every accepted push and pop.
- R10: A push into a full queue with no pop in the same cycle is dropped. On the receive side it sets overrun, which stays set until a receive flush (R3 or R4).
- R11: While disabled, pushes and pops are ignored and no overrun is recorded.
- R12: A push and a pop in the same cycle are both accepted, even when the queue is full, leaving the count unchanged. A flush in the same cycle as a push or pop overrides them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | One-cycle control write strobe |
| cfg_data | input | 8 | Control byte written with the strobe |
| rx_push | input | 1 | Push a received byte |
| rx_wdata | input | 8 | Received byte to push |
| rx_pop | input | 1 | Pop the oldest received byte |
| rx_rdata | output | 8 | Oldest received byte |
| rx_count | output | 5 | Receive occupancy |
| rx_full | output | 1 | Receive queue full |
| rx_empty | output | 1 | Receive queue empty |
| rx_overrun | output | 1 | Sticky receive overrun flag |
| rx_irq | output | 1 | Receive threshold interrupt request |
| tx_push | input | 1 | Push a byte to transmit |
| tx_wdata | input | 8 | Byte to transmit |
| tx_pop | input | 1 | Pop the oldest byte to transmit |
| tx_rdata | output | 8 | Oldest byte to transmit |
| tx_count | output | 5 | Transmit occupancy |
| tx_full | output | 1 | Transmit queue full |
| tx_empty | output | 1 | Transmit queue empty |

## Verification
The bench builds the block with its default values: 8-bit data, a depth of 16 and thresholds 1, 4, 8 and 14. This depth is small enough that every occupancy from empty to full, under all four threshold codes, is reached in a directed sweep. The full boundary can then be struck on purpose for the dropped push and same-cycle push and pop cases. A long stretch of mixed random pushes, pops and control writes is then compared cycle by cycle with a queue model computed in the bench.

// File: rtl/sio_fifo_pkg.sv
// Shared constants and types for the serial port FIFO pair.
// Assumes a control byte of 8 bits. Field positions are fixed because
// software encodes them.
package sio_fifo_pkg;
    localparam int CFG_W       = 8;
    localparam int EN_BIT      = 0;
    localparam int RXCLR_BIT   = 1;
    localparam int TXCLR_BIT   = 2;
    localparam int RESV_LSB    = 3;
    localparam int RESV_W      = 3;
    localparam int TRIG_LSB    = 6;
    localparam int TRIG_W      = 2;

    typedef enum logic [TRIG_W-1:0] {
        TRIG_SEL_A = 2'b00,
        TRIG_SEL_B = 2'b01,
        TRIG_SEL_C = 2'b10,
        TRIG_SEL_D = 2'b11
    } trig_sel_e;

    typedef struct packed {
        logic      en;
        trig_sel_e trig;
    } fifo_cfg_t;
endpackage

// File: rtl/sio_fifo_ctrl.sv
// Control byte decoder. It keeps the enable and the threshold code, and it
// turns flush commands and enable changes into one-cycle flush pulses.
// Assumes cfg_wr is high for one cycle per write. Nothing is read back.
module sio_fifo_ctrl
    import sio_fifo_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_wr,
    input  logic [CFG_W-1:0]     cfg_data,
    output fifo_cfg_t            cfg_q,
    output logic                 rx_flush,
    output logic                 tx_flush
);
    logic             en_flip;
    logic             fields_ok;
    logic [RESV_W-1:0] resv_unused;

    // Decode the write into flush pulses. Reserved bits are dropped.
    always_comb begin
        en_flip     = cfg_wr && (cfg_data[EN_BIT] != cfg_q.en);
        fields_ok   = cfg_wr && cfg_data[EN_BIT];
        rx_flush    = en_flip || (fields_ok && cfg_data[RXCLR_BIT]);
        tx_flush    = en_flip || (fields_ok && cfg_data[TXCLR_BIT]);
        resv_unused = cfg_data[RESV_LSB +: RESV_W];
    end

    // Hold the enable and the threshold code. Upper fields load only when enabling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (cfg_wr) begin
            cfg_q.en <= cfg_data[EN_BIT];
            if (cfg_data[EN_BIT]) begin
                cfg_q.trig <= trig_sel_e'(cfg_data[TRIG_LSB +: TRIG_W]);
            end
        end
    end
endmodule

// File: rtl/sio_byte_fifo.sv
// Circular FIFO with show-ahead read data, an occupancy count and a flush.
// A flush overrides push and pop. While en is low the queue is frozen.
// TRACK_OVR = 1 adds a sticky flag for dropped pushes, cleared by a flush.
// Assumes DEPTH >= 2. Any depth works because the pointers wrap explicitly.
module sio_byte_fifo #(
    parameter int DATA_W    = 8,
    parameter int DEPTH     = 16,
    parameter bit TRACK_OVR = 1'b1,
    localparam int AW       = $clog2(DEPTH),
    localparam int CW       = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              flush,
    input  logic              push,
    input  logic [DATA_W-1:0] wdata,
    input  logic              pop,
    output logic [DATA_W-1:0] rdata,
    output logic [CW-1:0]     count,
    output logic              full,
    output logic              empty,
    output logic              overrun
);
    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wr_ptr;
    logic [AW-1:0]     rd_ptr;
    logic              push_ok;
    logic              pop_ok;
    logic              drop;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Flags and accept conditions. A pop frees a slot for a push in the same cycle.
    always_comb begin
        full    = (count == CW'(DEPTH));
        empty   = (count == '0);
        pop_ok  = en && !flush && pop && !empty;
        push_ok = en && !flush && push && (!full || pop_ok);
        drop    = en && !flush && push && !push_ok;
        rdata   = mem[rd_ptr];
    end

    // Storage write. The array has no reset.
    always_ff @(posedge clk) begin
        if (push_ok) begin
            mem[wr_ptr] <= wdata;
        end
    end

    // Pointer and occupancy update. A flush wins over everything else.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) wr_ptr <= bump(wr_ptr);
            if (pop_ok)  rd_ptr <= bump(rd_ptr);
            case ({push_ok, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    generate
        if (TRACK_OVR) begin : g_ovr
            logic ovr_q;
            // Sticky dropped-push flag, cleared only by a flush.
            always_ff @(posedge clk) begin
                if (!rst_n || flush) ovr_q <= 1'b0;
                else if (drop)       ovr_q <= 1'b1;
            end
            assign overrun = ovr_q;
        end else begin : g_no_ovr
            logic drop_unused;
            assign drop_unused = drop;
            assign overrun     = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/sio_rx_trigger.sv
// Maps the 2-bit threshold code to a byte count and compares it with receive
// occupancy. The result is purely combinational.
// Assumes every level is between 1 and the queue depth.
module sio_rx_trigger
    import sio_fifo_pkg::*;
#(
    parameter int CW  = 5,
    parameter int LV0 = 1,
    parameter int LV1 = 4,
    parameter int LV2 = 8,
    parameter int LV3 = 14
) (
    input  logic          en,
    input  trig_sel_e     sel,
    input  logic [CW-1:0] count,
    output logic          irq
);
    logic [CW-1:0] level;

    // Decode the non-linear threshold and compare it with occupancy.
    always_comb begin
        case (sel)
            TRIG_SEL_A: level = CW'(LV0);
            TRIG_SEL_B: level = CW'(LV1);
            TRIG_SEL_C: level = CW'(LV2);
            default:    level = CW'(LV3);
        endcase
        irq = en && (count >= level);
    end
endmodule

// File: rtl/sio_fifo_pair.sv
// Receive and transmit byte queues for a serial port, driven by a single
// write-only control byte, with a receive threshold interrupt request.
// Assumes a one-cycle cfg_wr strobe and a synchronous active-low reset.
module sio_fifo_pair #(
    parameter int DATA_W  = 8,
    parameter int DEPTH   = 16,
    parameter int TRIG_L0 = 1,
    parameter int TRIG_L1 = 4,
    parameter int TRIG_L2 = 8,
    parameter int TRIG_L3 = 14,
    localparam int CW     = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [7:0]        cfg_data,
    input  logic              rx_push,
    input  logic [DATA_W-1:0] rx_wdata,
    input  logic              rx_pop,
    output logic [DATA_W-1:0] rx_rdata,
    output logic [CW-1:0]     rx_count,
    output logic              rx_full,
    output logic              rx_empty,
    output logic              rx_overrun,
    output logic              rx_irq,
    input  logic              tx_push,
    input  logic [DATA_W-1:0] tx_wdata,
    input  logic              tx_pop,
    output logic [DATA_W-1:0] tx_rdata,
    output logic [CW-1:0]     tx_count,
    output logic              tx_full,
    output logic              tx_empty
);
    import sio_fifo_pkg::*;

    fifo_cfg_t cfg_q;
    logic      fifo_en;
    logic      rx_flush;
    logic      tx_flush;
    logic      tx_ovr_unused;

    assign fifo_en = cfg_q.en;

    sio_fifo_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_wr   (cfg_wr),
        .cfg_data (cfg_data),
        .cfg_q    (cfg_q),
        .rx_flush (rx_flush),
        .tx_flush (tx_flush)
    );

    sio_byte_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH), .TRACK_OVR(1'b1)) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (fifo_en),
        .flush   (rx_flush),
        .push    (rx_push),
        .wdata   (rx_wdata),
        .pop     (rx_pop),
        .rdata   (rx_rdata),
        .count   (rx_count),
        .full    (rx_full),
        .empty   (rx_empty),
        .overrun (rx_overrun)
    );

    sio_byte_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH), .TRACK_OVR(1'b0)) u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (fifo_en),
        .flush   (tx_flush),
        .push    (tx_push),
        .wdata   (tx_wdata),
        .pop     (tx_pop),
        .rdata   (tx_rdata),
        .count   (tx_count),
        .full    (tx_full),
        .empty   (tx_empty),
        .overrun (tx_ovr_unused)
    );

    sio_rx_trigger #(
        .CW(CW), .LV0(TRIG_L0), .LV1(TRIG_L1), .LV2(TRIG_L2), .LV3(TRIG_L3)
    ) u_trig (
        .en    (fifo_en),
        .sel   (cfg_q.trig),
        .count (rx_count),
        .irq   (rx_irq)
    );
endmodule

// File: rtl/sio_fifo_pair_chk.sv
// Property checker for sio_fifo_pair, attached to it by the bind at the end of the file.
module sio_fifo_pair_chk #(
    parameter int DEPTH = 16,
    parameter int CW    = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cfg_wr,
    input logic [2:0]    cfg_low,
    input logic          en,
    input logic [CW-1:0] rx_count,
    input logic          rx_full,
    input logic          rx_empty,
    input logic          rx_overrun,
    input logic          rx_irq,
    input logic [CW-1:0] tx_count,
    input logic          tx_empty
);
    logic rx_clear;
    assign rx_clear = cfg_wr && ((cfg_low[0] != en) || (cfg_low[0] && cfg_low[1]));

    AST_RX_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(rx_full && rx_empty)); // R9
    AST_RX_COUNT_CAP: assert property (@(posedge clk) disable iff (!rst_n) rx_count <= CW'(DEPTH)); // R9
    AST_TOGGLE_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n) (cfg_wr && (cfg_low[0] != en)) |=> (rx_empty && tx_empty && !rx_overrun)); // R3
    AST_RX_FLUSH: assert property (@(posedge clk) disable iff (!rst_n) (cfg_wr && cfg_low[0] && cfg_low[1]) |=> (rx_count == '0 && !rx_overrun)); // R4
    AST_TX_FLUSH: assert property (@(posedge clk) disable iff (!rst_n) (cfg_wr && cfg_low[0] && cfg_low[2]) |=> (tx_count == '0)); // R5
    AST_IRQ_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n) rx_irq |-> (!rx_empty && en)); // R8
    AST_IRQ_AT_FULL: assert property (@(posedge clk) disable iff (!rst_n) (en && rx_full) |-> rx_irq); // R7
    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (rx_overrun && !rx_clear) |=> rx_overrun); // R10
    AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n) (!en && !cfg_wr) |=> ($stable(rx_count) && $stable(tx_count) && $stable(rx_overrun))); // R11
endmodule

bind sio_fifo_pair sio_fifo_pair_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_wr     (cfg_wr),
    .cfg_low    (cfg_data[2:0]),
    .en         (fifo_en),
    .rx_count   (rx_count),
    .rx_full    (rx_full),
    .rx_empty   (rx_empty),
    .rx_overrun (rx_overrun),
    .rx_irq     (rx_irq),
    .tx_count   (tx_count),
    .tx_empty   (tx_empty)
);

// File: tb/tb_sio_fifo_pair.sv
module tb_sio_fifo_pair;
    localparam int DW    = 8;
    localparam int DEPTH = 16;
    localparam int CW    = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_wr = 1'b0;
    logic [7:0]    cfg_data = '0;
    logic          rx_push = 1'b0, rx_pop = 1'b0, tx_push = 1'b0, tx_pop = 1'b0;
    logic [DW-1:0] rx_wdata = '0, tx_wdata = '0;
    logic [DW-1:0] rx_rdata, tx_rdata;
    logic [CW-1:0] rx_count, tx_count;
    logic          rx_full, rx_empty, rx_overrun, rx_irq, tx_full, tx_empty;

    always #10 clk = ~clk;

    sio_fifo_pair dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_data(cfg_data),
        .rx_push(rx_push), .rx_wdata(rx_wdata), .rx_pop(rx_pop),
        .rx_rdata(rx_rdata), .rx_count(rx_count), .rx_full(rx_full),
        .rx_empty(rx_empty), .rx_overrun(rx_overrun), .rx_irq(rx_irq),
        .tx_push(tx_push), .tx_wdata(tx_wdata), .tx_pop(tx_pop),
        .tx_rdata(tx_rdata), .tx_count(tx_count), .tx_full(tx_full),
        .tx_empty(tx_empty)
    );

    int   n_chk = 0;
    int   n_err = 0;
    bit   done  = 1'b0;
    logic [7:0] rxq[$];
    logic [7:0] txq[$];
    bit   m_en  = 1'b0;
    logic [1:0] m_trig = 2'b00;
    bit   m_ovr = 1'b0;

    function automatic int lvl(input logic [1:0] t);
        case (t)
            2'b00:   return 1;
            2'b01:   return 4;
            2'b10:   return 8;
            default: return 14;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Compare every output with the model. Fields map to R8, R9 and R10.
    task automatic compare_all();
        int exp_irq;
        exp_irq = (m_en && rxq.size() >= lvl(m_trig)) ? 1 : 0;
        chk(int'(rx_count) == rxq.size(), "R9 rx_count", int'(rx_count), rxq.size());
        chk(int'(tx_count) == txq.size(), "R9 tx_count", int'(tx_count), txq.size());
        chk(rx_full == (rxq.size() == DEPTH), "R9 rx_full", rx_full, rxq.size() == DEPTH);
        chk(rx_empty == (rxq.size() == 0), "R9 rx_empty", rx_empty, rxq.size() == 0);
        chk(tx_full == (txq.size() == DEPTH), "R9 tx_full", tx_full, txq.size() == DEPTH);
        chk(tx_empty == (txq.size() == 0), "R9 tx_empty", tx_empty, txq.size() == 0);
        if (rxq.size() > 0) chk(rx_rdata == rxq[0], "R9 rx_rdata", rx_rdata, rxq[0]);
        if (txq.size() > 0) chk(tx_rdata == txq[0], "R9 tx_rdata", tx_rdata, txq[0]);
        chk(rx_overrun == m_ovr, "R10 rx_overrun", rx_overrun, m_ovr);
        chk(int'(rx_irq) == exp_irq, "R8 rx_irq", rx_irq, exp_irq);
    endtask

    // One clock cycle: drive the inputs, advance the model, then check after the edge.
    task automatic cyc(input bit wr, input logic [7:0] d,
                       input bit rpu, input logic [7:0] rd, input bit rpo,
                       input bit tpu, input logic [7:0] td, input bit tpo);
        bit fl_rx, fl_tx, flip, popok, pushok;
        cfg_wr = wr; cfg_data = d;
        rx_push = rpu; rx_wdata = rd; rx_pop = rpo;
        tx_push = tpu; tx_wdata = td; tx_pop = tpo;
        flip  = wr && (d[0] != m_en);
        fl_rx = flip || (wr && d[0] && d[1]);
        fl_tx = flip || (wr && d[0] && d[2]);
        if (fl_rx) begin
            rxq.delete(); m_ovr = 1'b0;
        end else if (m_en) begin
            popok  = rpo && rxq.size() > 0;
            pushok = rpu && (rxq.size() < DEPTH || popok);
            if (rpu && !pushok) m_ovr = 1'b1;
            if (popok)  void'(rxq.pop_front());
            if (pushok) rxq.push_back(rd);
        end
        if (fl_tx) begin
            txq.delete();
        end else if (m_en) begin
            popok  = tpo && txq.size() > 0;
            pushok = tpu && (txq.size() < DEPTH || popok);
            if (popok)  void'(txq.pop_front());
            if (pushok) txq.push_back(td);
        end
        if (wr) begin
            m_en = d[0];
            if (d[0]) m_trig = d[7:6];
        end
        @(posedge clk);
        #2;
        compare_all();
    endtask

    task automatic cfg(input logic [7:0] d);
        cyc(1'b1, d, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0);
    endtask

    initial begin
        #(20 * 150000);
        n_err++;
        $display("FAIL watchdog expired actual=0 expected=1");
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        end
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        rst_n = 1'b1;
        // R1: reset state
        chk(rx_count == 0 && tx_count == 0, "R1 counts", int'(rx_count) + int'(tx_count), 0);
        chk(rx_empty && tx_empty && !rx_full && !tx_full, "R1 flags", {rx_empty, tx_empty, rx_full, tx_full}, 4'b1100);
        chk(!rx_overrun && !rx_irq, "R1 overrun/irq", {rx_overrun, rx_irq}, 0);

        // R11: pushes while disabled are ignored
        cyc(1'b0, 8'h00, 1'b1, 8'h11, 1'b0, 1'b1, 8'h22, 1'b0);
        chk(rx_count == 0 && tx_count == 0, "R11 push while off", int'(rx_count) + int'(tx_count), 0);

        // R2: enable with code 00 loaded in the same write
        cfg(8'h01);
        // R9, R10: fill receive to 16, then one more push is dropped
        for (int i = 0; i < DEPTH; i++) cyc(1'b0, 8'h00, 1'b1, 8'(8'hA0 + i), 1'b0, 1'b1, 8'(8'h50 + i), 1'b0);
        chk(rx_full && tx_full, "R9 full at 16", {rx_full, tx_full}, 2'b11);
        cyc(1'b0, 8'h00, 1'b1, 8'hEE, 1'b0, 1'b0, 8'h00, 1'b0);
        chk(rx_overrun && rx_count == 16, "R10 drop on full", rx_overrun, 1);
        // R12: push and pop together on a full queue keep it at 16
        cyc(1'b0, 8'h00, 1'b1, 8'h77, 1'b1, 1'b1, 8'h66, 1'b1);
        chk(rx_count == 16 && rx_rdata == 8'hA1, "R12 push+pop at full", rx_rdata, 8'hA1);
        // R10: overrun survives pops
        for (int i = 0; i < DEPTH; i++) cyc(1'b0, 8'h00, 1'b0, 8'h00, 1'b1, 1'b0, 8'h00, 1'b0);
        chk(rx_overrun, "R10 sticky after drain", rx_overrun, 1);
        // R5: transmit flush leaves receive intact
        cyc(1'b0, 8'h00, 1'b1, 8'h31, 1'b0, 1'b0, 8'h00, 1'b0);
        cfg(8'h05);
        chk(tx_count == 0 && rx_count == 1 && rx_overrun, "R5 tx flush only", int'(tx_count), 0);
        // R4: receive flush, then a write without bit 1 does not flush again
        cfg(8'h03);
        chk(rx_count == 0 && !rx_overrun, "R4 rx flush", int'(rx_count), 0);
        cyc(1'b0, 8'h00, 1'b1, 8'h42, 1'b0, 1'b0, 8'h00, 1'b0);
        cfg(8'h01);
        chk(rx_count == 1, "R4 flush is one-time", int'(rx_count), 1);
        // R6: reserved bits have no effect
        cfg(8'h39);
        chk(rx_count == 1 && rx_irq, "R6 reserved ignored", int'(rx_count), 1);
        cyc(1'b0, 8'h00, 1'b0, 8'h00, 1'b1, 1'b0, 8'h00, 1'b0);

        // R7, R8: sweep every code over every occupancy up and down
        for (int t = 0; t < 4; t++) begin
            cfg(8'((t << 6) | 8'h39));
            for (int k = 0; k < DEPTH; k++) begin
                cyc(1'b0, 8'h00, 1'b1, 8'(k * 7), 1'b0, 1'b0, 8'h00, 1'b0);
                chk(rx_irq == (k + 1 >= lvl(2'(t))), "R7 threshold rising", rx_irq, k + 1 >= lvl(2'(t)));
            end
            for (int k = DEPTH - 1; k >= 0; k--) begin
                cyc(1'b0, 8'h00, 1'b0, 8'h00, 1'b1, 1'b0, 8'h00, 1'b0);
                chk(rx_irq == (k >= lvl(2'(t))), "R8 threshold falling", rx_irq, k >= lvl(2'(t)));
            end
        end

        // R3: disabling empties both queues; R2: bits 7:1 of that write are discarded
        cfg(8'hC1);
        for (int i = 0; i < 5; i++) cyc(1'b0, 8'h00, 1'b1, 8'(i), 1'b0, 1'b1, 8'(i), 1'b0);
        cfg(8'hC6);
        chk(rx_count == 0 && tx_count == 0 && !rx_irq, "R3 toggle off empties", int'(rx_count) + int'(tx_count), 0);
        cyc(1'b0, 8'h00, 1'b1, 8'h12, 1'b0, 1'b1, 8'h34, 1'b0);
        chk(rx_count == 0, "R2 disabled by bit0=0", int'(rx_count), 0);
        // R12: flush beats a same-cycle push
        cfg(8'h41);
        cyc(1'b0, 8'h00, 1'b1, 8'h01, 1'b0, 1'b1, 8'h02, 1'b0);
        cyc(1'b1, 8'h07, 1'b1, 8'h03, 1'b0, 1'b1, 8'h04, 1'b0);
        chk(rx_count == 0 && tx_count == 0, "R12 flush beats push", int'(rx_count) + int'(tx_count), 0);
        // R3: enabling also flushes (queue is empty, overrun stays clear)
        cfg(8'h00);
        cfg(8'h01);
        chk(rx_empty && !rx_overrun, "R3 toggle on", rx_empty, 1);

        // Random mix compared with the model every cycle
        for (int n = 0; n < 4000; n++) begin
            logic [7:0] d;
            bit wr;
            d  = 8'($urandom);
            wr = ($urandom % 40) == 0;
            if (($urandom % 6) != 0) d[0] = 1'b1;
            cyc(wr, d, ($urandom % 2) == 0, 8'($urandom), ($urandom % 5) < 2,
                ($urandom % 2) == 0, 8'($urandom), ($urandom % 5) < 2);
        end

        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        end
        $finish;
    end
endmodule